// File: doc/BRIEF.md
# Memory Array Accumulate Engine

The engine adds up a run of consecutive 32-bit words held in a word-organised memory. A 5-bit size input selects how many words to add, from 0 to 31. A rising edge on the go input starts one accumulation. The engine issues one read per element at byte addresses 0, 4, 8 and so on. Each returned word is added into a 32-bit running total, which wraps on overflow.

A busy flag marks the span of the loop, so its high time measures how long the accumulation takes. When the total is final, a one-cycle done pulse is produced. The total is then held until the next start. A separate 5-bit output carries only the low bits of the total, for a small numeric display.

The memory sits outside the block. It is a synchronous-read array: it returns data one cycle after a read request.

Top module: `array_sum_engine`

## Requirements
- R1: When the synchronous reset `rst` is high at a clock edge, the next cycle shows `sum_o` = 0, `busy_o` = 0, `done_o` = 0 and `mem_rd_en_o` = 0. This holds even if an accumulation was in progress.
- R2: Only a 0-to-1 change of `go_i` seen while the engine is idle starts an accumulation. Holding `go_i` high for several cycles starts exactly one accumulation.
- R3: For a size N > 0, `mem_rd_en_o` is high for exactly N consecutive cycles. On the k-th of those cycles (k from 0), `mem_addr_o` equals 4*k.
- R4: Read data is taken from `mem_rd_data_i` on the cycle after the matching read request. The final `sum_o` is the sum of memory words 0 to N-1; for words 36, 26, 69, 57 and N = 4, it is 188.
- R5: `disp_o` always equals the low five bits of `sum_o`. A total of 188 shows as 28.
- R6: For N > 0, `busy_o` is high for exactly N+2 cycles. It rises one cycle before the first read and falls after the cycle in which the last word is added.
- R7: `done_o` is high for exactly one cycle, the cycle right after `busy_o` falls. `sum_o` then keeps the final total until the next accepted start.
- R8: A size of 0 produces `done_o` in the first cycle after the start. There is no memory read, `busy_o` never rises, and `sum_o` is 0.
- R9: A rising edge on `go_i` while an accumulation is running is ignored. The result, the number of reads and the busy time are unchanged.
- R10: The total is taken modulo 2^32: 0xFFFFFFF0 plus 0x20 gives 0x00000010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| go_i | input | 1 | Start request; its rising edge starts one accumulation |
| count_i | input | 5 | Number of words to add, sampled at the start |
| mem_rd_en_o | output | 1 | Read request to the memory |
| mem_addr_o | output | 7 | Byte address of the requested word |
| mem_rd_data_i | input | 32 | Word returned by the memory one cycle after a request |
| busy_o | output | 1 | High while the accumulation loop runs |
| done_o | output | 1 | One-cycle pulse when the total is final |
| sum_o | output | 32 | Running and final 32-bit total |
| disp_o | output | 5 | Low five bits of the total, for a display |

## Verification
The assertions take for granted that the memory answers every read request on the very next cycle. They also assume `count_i` is steady in the cycle a start is accepted, because the address and zero-size properties compare against the value sampled there.

The bench's memory model is a registered array that always answers one cycle later. `count_i` is set before `go_i` rises and is not changed during a run. Re-presses of `go_i` happen only inside long runs, so the ignore rule is exercised without ever starting from an undefined size.

// File: rtl/sum_pkg.sv
package sum_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_RUN,
    ST_DRAIN,
    ST_FINISH
  } eng_state_t;
endpackage

// File: rtl/go_edge.sv
module go_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/sum_ctrl.sv
module sum_ctrl #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_rise_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             last_issue_i,
  output logic             start_o,
  output logic             rd_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  import sum_pkg::*;

  eng_state_t state_q, state_d;
  logic [CNT_W-1:0] cnt_q;

  assign start_o = go_rise_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_o) state_d = (count_i == '0) ? ST_FINISH : ST_PREP;
      ST_PREP:   state_d = ST_RUN;
      ST_RUN:    if (last_issue_i) state_d = ST_DRAIN;
      ST_DRAIN:  state_d = ST_FINISH;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start_o) cnt_q <= count_i;
    end
  end

  assign rd_en_o = (state_q == ST_RUN);
  assign busy_o  = (state_q == ST_PREP) || (state_q == ST_RUN) || (state_q == ST_DRAIN);
  assign done_o  = (state_q == ST_FINISH);
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/sum_addr_gen.sv
module sum_addr_gen #(
  parameter int CNT_W  = 5,
  parameter int ADDR_W = CNT_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  logic [CNT_W-1:0] idx_q;

  function automatic logic [ADDR_W-1:0] word_to_byte(input logic [CNT_W-1:0] idx);
    return {idx, 2'b00};
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clr_i) idx_q <= '0;
    else if (step_i)  idx_q <= idx_q + CNT_W'(1);
  end

  assign addr_o = word_to_byte(idx_q);
  assign last_o = (idx_q == cnt_i - CNT_W'(1));
endmodule

// File: rtl/sum_datapath.sv
module sum_datapath #(
  parameter int DATA_W = 32,
  parameter int DISP_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [DISP_W-1:0] disp_o,
  output logic              add_fire_o
);
  logic              vld_q;
  logic [DATA_W-1:0] sum_q;

  function automatic logic [DATA_W-1:0] acc_step(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [DISP_W-1:0] low_view(input logic [DATA_W-1:0] v);
    return v[DISP_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      vld_q <= 1'b0;
      sum_q <= '0;
    end else begin
      vld_q <= rd_en_i;
      if (vld_q) sum_q <= acc_step(sum_q, rd_data_i);
    end
  end

  assign add_fire_o = vld_q;
  assign sum_o      = sum_q;
  assign disp_o     = low_view(sum_q);
endmodule

// File: rtl/array_sum_engine.sv
module array_sum_engine #(
  parameter int  DATA_W = 32,
  parameter int  CNT_W  = 5,
  parameter int  DISP_W = 5,
  localparam int ADDR_W = CNT_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              mem_rd_en_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] sum_o,
  output logic [DISP_W-1:0] disp_o
);
  logic             go_rise;
  logic             start_w;
  logic             last_issue;
  logic             add_fire;
  logic [CNT_W-1:0] cnt_w;

  go_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (go_i),
    .rise_o (go_rise)
  );

  sum_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .go_rise_i    (go_rise),
    .count_i      (count_i),
    .last_issue_i (last_issue),
    .start_o      (start_w),
    .rd_en_o      (mem_rd_en_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .cnt_o        (cnt_w)
  );

  sum_addr_gen #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_addr (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (start_w),
    .step_i (mem_rd_en_o),
    .cnt_i  (cnt_w),
    .addr_o (mem_addr_o),
    .last_o (last_issue)
  );

  sum_datapath #(.DATA_W(DATA_W), .DISP_W(DISP_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (start_w),
    .rd_en_i    (mem_rd_en_o),
    .rd_data_i  (mem_rd_data_i),
    .sum_o      (sum_o),
    .disp_o     (disp_o),
    .add_fire_o (add_fire)
  );
endmodule

// File: rtl/array_sum_engine_chk.sv
module array_sum_engine_chk #(
  parameter int  DATA_W = 32,
  parameter int  CNT_W  = 5,
  localparam int ADDR_W = CNT_W + 2
) (
  input logic              clk,
  input logic              rst,
  input logic [CNT_W-1:0]  count_i,
  input logic              start_w,
  input logic              add_fire,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] sum
);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_read_in_busy_R6: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> busy);

  assert_first_addr_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_en) |-> (addr == '0));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (!rd_en || addr == $past(addr) + ADDR_W'(4)));

  assert_zero_size_R8: assert property (@(posedge clk) disable iff (rst)
    (start_w && count_i == '0) |=> (done && !busy));

  assert_busy_cause_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start_w));

  assert_sum_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start_w) |=> $stable(sum));

  assert_add_in_busy_R4: assert property (@(posedge clk) disable iff (rst)
    add_fire |-> busy);
endmodule

bind array_sum_engine array_sum_engine_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .count_i  (count_i),
  .start_w  (start_w),
  .add_fire (add_fire),
  .rd_en    (mem_rd_en_o),
  .addr     (mem_addr_o),
  .busy     (busy_o),
  .done     (done_o),
  .sum      (sum_o)
);

// File: tb/tb_array_sum_engine.sv
module tb_array_sum_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        go_i = 1'b0;
  logic [4:0]  count_i = '0;
  logic        rd_en;
  logic [6:0]  addr;
  logic [31:0] rdata = '0;
  logic        busy, done;
  logic [31:0] sum;
  logic [4:0]  disp;

  logic [31:0] mem [32];
  int checks = 0;
  int fails  = 0;

  localparam int NVEC = 8;
  localparam int unsigned VEC_N [NVEC] = '{4, 1, 31, 0, 2, 17, 3, 8};

  always #4 clk = ~clk;

  array_sum_engine dut (
    .clk(clk), .rst(rst), .go_i(go_i), .count_i(count_i),
    .mem_rd_en_o(rd_en), .mem_addr_o(addr), .mem_rd_data_i(rdata),
    .busy_o(busy), .done_o(done), .sum_o(sum), .disp_o(disp)
  );

  always @(posedge clk) if (rd_en) rdata <= mem[addr[6:2]];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic run_case(input int n, input bit repress);
    logic [31:0] exp = '0;
    int reads = 0, busy_n = 0, done_at = -1, done_n = 0;
    int first_busy = -1, first_read = -1;
    bit addr_ok = 1'b1;
    int exp_done;
    for (int i = 0; i < n; i++) exp += mem[i];
    count_i = n[4:0];
    for (int c = 0; c < n + 12; c++) begin
      go_i = (c < 3) || (repress && c >= 10 && c < 13);
      @(posedge clk); @(negedge clk);
      if (rd_en) begin
        if (first_read < 0) first_read = c;
        if (addr != 7'(reads * 4)) addr_ok = 1'b0;
        reads++;
      end
      if (busy) begin
        if (first_busy < 0) first_busy = c;
        busy_n++;
      end
      if (done) begin
        done_n++;
        if (done_at < 0) done_at = c;
      end
    end
    go_i = 1'b0;
    exp_done = (n == 0) ? 0 : n + 2;
    chk(reads == n, "R3 read count", 32'(reads), 32'(n));
    chk(addr_ok, "R3 address sequence", 32'(addr_ok), 32'd1);
    chk(sum == exp, "R4 total", sum, exp);
    chk(disp == exp[4:0], "R5 display view", 32'(disp), 32'(exp[4:0]));
    chk(busy_n == exp_done, "R6 busy cycles", 32'(busy_n), 32'(exp_done));
    if (n > 0) chk(first_read == first_busy + 1, "R6 busy before read", 32'(first_read), 32'(first_busy + 1));
    chk(done_n == 1, "R2 R7 single done", 32'(done_n), 32'd1);
    chk(done_at == exp_done, "R7 R8 done cycle", 32'(done_at), 32'(exp_done));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    mem[0] = 32'd36; mem[1] = 32'd26; mem[2] = 32'd69; mem[3] = 32'd57;
    for (int i = 4; i < 32; i++) mem[i] = 32'((i * 29 + 7) % 100);

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(sum == 0 && !busy && !done && !rd_en, "R1 reset state", sum, 32'd0);
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) run_case(int'(VEC_N[v]), 1'b0);

    // R4 R5 known sample: 36+26+69+57
    run_case(4, 1'b0);
    chk(sum == 32'd188, "R4 sample total", sum, 32'd188);
    chk(disp == 5'd28, "R5 sample display", 32'(disp), 32'd28);

    // R7 total held while idle
    repeat (5) @(negedge clk);
    chk(sum == 32'd188, "R7 hold after done", sum, 32'd188);

    // R9 re-press during a long run is ignored
    run_case(31, 1'b1);

    // R10 wrap modulo 2^32
    mem[0] = 32'hFFFF_FFF0; mem[1] = 32'h0000_0020;
    run_case(2, 1'b0);
    chk(sum == 32'h10, "R10 wrap total", sum, 32'h10);

    // R1 reset in the middle of a run
    count_i = 5'd31;
    go_i = 1'b1;
    repeat (6) @(negedge clk);
    go_i = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk(sum == 0 && !busy && !done && !rd_en, "R1 reset mid-run", {busy, done, rd_en, 29'(sum)}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    run_case(3, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule